// File: doc/BRIEF.md
# Data-Strobe Serial Transmit Encoder

This block turns a narrow parallel word coming from a link-layer controller into a two-wire serial data-strobe pair. It runs from one fast bit clock. From that clock it derives the word clock that it hands to the link. Once per word period it latches the link's word and an enable. During the next word period it sends the word's bits one at a time, least significant bit first, on the data line. The strobe line is built so that exactly one of the two lines changes state in each bit cell, which lets the receiver recover a clock from the pair.

A rate-select input picks between full rate, where each bit cell is one bit-clock cycle, and half rate, where each bit cell lasts two cycles. Both the rate and the enable are taken at the same word boundary as the data, so each applies to the word period that carries that word. While a word is marked as not for transmission, both lines sit low and the external line driver is switched off through a single drive-enable output.

Top module: `ds_tx_encoder`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the following cycle shows `tx_data`, `tx_strobe` and `tx_drive_en` low and `link_clk` high.
- R2: `din`, `tx_en` and `mode_half` are sampled on the `clk` edge at which `link_clk` rises. The sampled word is sent during the word period that begins at the next such edge. `link_clk` rises only on that word-boundary edge.
- R3: Bit `din[0]` occupies the first bit cell of its word period and `din[1]` the second.
- R4: In full rate (`mode_half` = 0) a bit cell lasts one `clk` cycle. The word period is 2 cycles, with `link_clk` high in its first cycle and low in its second.
- R5: In half rate (`mode_half` = 1) a bit cell lasts two `clk` cycles. The word period is 4 cycles, with `link_clk` high for the first 2 and low for the last 2.
- R6: A change of `mode_half` takes effect only for the word period of the word sampled with it. Within a word period the rate never changes.
- R7: In each enabled bit cell, `tx_strobe` inverts when the new data bit equals the data bit of the previous cell and holds otherwise. After reset or an idle cell, the previous data and strobe count as 0.
- R8: Across two consecutive enabled bit cells, `tx_data` XOR `tx_strobe` changes value.
- R9: During a word period whose word was sampled with `tx_en` = 0, `tx_data` and `tx_strobe` are low whatever `din` held.
- R10: `tx_drive_en` is high exactly during the word periods that carry words sampled with `tx_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_half | input | 1 | 0 = full rate, 1 = half rate; sampled at word boundary |
| tx_en | input | 1 | 1 = word is transmitted; sampled at word boundary |
| din | input | WORD_W (2) | Parallel word from the link; bit 0 is sent first |
| link_clk | output | 1 | Word clock for the link; rises at each word boundary |
| tx_data | output | 1 | Serial data line |
| tx_strobe | output | 1 | Serial strobe line |
| tx_drive_en | output | 1 | Enable for the external line driver |

## Verification
The bench feeds runs of identical words to force the strobe to toggle every cell. It also sends alternating bits, where the strobe must hold. A design that inverted the strobe rule, or that forgot the last data bit across a word boundary, would break the data-XOR-strobe toggle at the seam between words. Rate switches in both directions check that a design does not apply the new rate mid-word, which would shift bits into the wrong cells. An idle word carrying non-zero data checks that stale bits or a live driver enable do not leak onto the lines. A reset inserted in the middle of traffic checks that the lines clear at once rather than after the current word finishes.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;

    typedef struct packed {
        logic data;
        logic strobe;
        logic drive;
    } line_t;

    localparam line_t LINE_IDLE = '{data: 1'b0, strobe: 1'b0, drive: 1'b0};

    // strobe inverts when the data line would otherwise stay put
    function automatic logic ds_next_strobe(logic new_bit, logic prev_bit, logic prev_strobe);
        return (new_bit == prev_bit) ? ~prev_strobe : prev_strobe;
    endfunction

endpackage

// File: rtl/ds_tx_rate_gen.sv
module ds_tx_rate_gen
    import ds_tx_pkg::*;
#(
    parameter int WORD_W   = 2,
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_half,
    output logic bit_tick,
    output logic word_end,
    output logic link_clk
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    rate_e          rate_q;
    logic [CW-1:0]  div_cnt;
    logic [IW-1:0]  bit_idx;

    always_comb begin
        if (rate_q == RATE_HALF) bit_tick = (div_cnt == CW'(HALF_DIV - 1));
        else                     bit_tick = 1'b1;
        word_end = bit_tick && (bit_idx == IW'(WORD_W - 1));
        link_clk = (bit_idx < IW'(WORD_W / 2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= RATE_FULL;
            div_cnt <= '0;
            bit_idx <= '0;
        end else begin
            if (bit_tick) div_cnt <= '0;
            else          div_cnt <= div_cnt + 1'b1;
            if (word_end) begin
                bit_idx <= '0;
                rate_q  <= mode_half ? RATE_HALF : RATE_FULL;
            end else if (bit_tick) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ds_tx_word_shift.sv
module ds_tx_word_shift #(
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              word_end,
    input  logic [WORD_W-1:0] din,
    input  logic              tx_en,
    output logic              next_bit,
    output logic              next_en
);
    logic [WORD_W-1:0] shreg;
    logic              en_q;

    always_comb begin
        next_bit = word_end ? din[0] : shreg[0];
        next_en  = word_end ? tx_en  : en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            en_q  <= 1'b0;
        end else if (word_end) begin
            shreg <= din >> 1;
            en_q  <= tx_en;
        end else if (bit_tick) begin
            shreg <= shreg >> 1;
        end
    end

endmodule

// File: rtl/ds_tx_line_enc.sv
module ds_tx_line_enc
    import ds_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_tick,
    input  logic  next_bit,
    input  logic  next_en,
    output line_t line
);
    line_t line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LINE_IDLE;
        end else if (bit_tick) begin
            if (next_en) begin
                line_q.data   <= next_bit;
                line_q.strobe <= ds_next_strobe(next_bit, line_q.data, line_q.strobe);
                line_q.drive  <= 1'b1;
            end else begin
                line_q <= LINE_IDLE;
            end
        end
    end

    assign line = line_q;

endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
    import ds_tx_pkg::*;
#(
    parameter int WORD_W   = 2,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_half,
    input  logic              tx_en,
    input  logic [WORD_W-1:0] din,
    output logic              link_clk,
    output logic              tx_data,
    output logic              tx_strobe,
    output logic              tx_drive_en
);
    logic  bit_tick;
    logic  word_end;
    logic  next_bit;
    logic  next_en;
    line_t line;

    ds_tx_rate_gen #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .mode_half(mode_half),
        .bit_tick (bit_tick),
        .word_end (word_end),
        .link_clk (link_clk)
    );

    ds_tx_word_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_tick(bit_tick),
        .word_end(word_end),
        .din     (din),
        .tx_en   (tx_en),
        .next_bit(next_bit),
        .next_en (next_en)
    );

    ds_tx_line_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .bit_tick(bit_tick),
        .next_bit(next_bit),
        .next_en (next_en),
        .line    (line)
    );

    assign tx_data     = line.data;
    assign tx_strobe   = line.strobe;
    assign tx_drive_en = line.drive;

endmodule

// File: rtl/ds_tx_encoder_chk.sv
module ds_tx_encoder_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic word_end,
    input logic link_clk,
    input logic tx_data,
    input logic tx_strobe,
    input logic tx_drive_en
);
    // R1
    lines_clear_chk: assert property (@(posedge clk)
        rst |=> (!tx_data && !tx_strobe && !tx_drive_en && link_clk));

    // R2
    link_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_clk) |-> $past(word_end));

    // R4
    cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(tx_data) && $stable(tx_strobe) && $stable(tx_drive_en)));

    // R7
    strobe_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && tx_drive_en) |=>
            (tx_drive_en -> ((tx_data == $past(tx_data)) == (tx_strobe != $past(tx_strobe)))));

    // R8
    xor_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && tx_drive_en) |=>
            (!tx_drive_en || ((tx_data ^ tx_strobe) != $past(tx_data ^ tx_strobe))));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_drive_en |-> (!tx_data && !tx_strobe));

endmodule

bind ds_tx_encoder ds_tx_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .word_end   (word_end),
    .link_clk   (link_clk),
    .tx_data    (tx_data),
    .tx_strobe  (tx_strobe),
    .tx_drive_en(tx_drive_en)
);

// File: tb/ds_tx_encoder_tb.sv
`timescale 1ns/1ps
module ds_tx_encoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_half = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] din = 2'b00;
    logic       link_clk, tx_data, tx_strobe, tx_drive_en;

    int total = 0;
    int bad   = 0;
    logic prev_link = 1'b1;
    logic pd = 1'b0, ps = 1'b0;

    always #2 clk = ~clk;

    ds_tx_encoder u_dut (
        .clk(clk), .rst(rst), .mode_half(mode_half), .tx_en(tx_en), .din(din),
        .link_clk(link_clk), .tx_data(tx_data), .tx_strobe(tx_strobe),
        .tx_drive_en(tx_drive_en)
    );

    // {half, enable, din[1:0]}
    localparam int NV = 16;
    localparam logic [3:0] VEC [NV] = '{
        4'b0100, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b0011, 4'b0101, 4'b1110,
        4'b1111, 4'b1001, 4'b1100, 4'b0110, 4'b1101, 4'b0111, 4'b0000, 4'b1110
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic wait_rise();
        bit found = 0;
        for (int n = 0; n < 8 && !found; n++) begin
            @(negedge clk);
            if (link_clk && !prev_link) found = 1;
            prev_link = link_clk;
        end
        chk("R2 link_clk rise", found, 1'b1);
    endtask

    task automatic drive(input logic [3:0] v);
        mode_half = v[3];
        tx_en     = v[2];
        din       = v[1:0];
    endtask

    // checks one word period; called at the first negedge of the period
    task automatic run_period(input logic [3:0] cur, input logic [3:0] nv);
        int   len, step;
        logic nd, ns, obs_x, prev_en;
        drive(nv);
        len  = cur[3] ? 4 : 2;
        step = len / 2;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            if (k % step == 0) begin
                prev_en = (pd !== 1'b0) || (ps !== 1'b0) || cur[2];
                if (cur[2]) begin
                    nd = cur[k / step];
                    ns = (nd == pd) ? ~ps : ps;
                end else begin
                    nd = 1'b0;
                    ns = 1'b0;
                end
                if (cur[2] && k > 0) begin
                    // R8: consecutive enabled cells inside the word
                    chk("R8 xor toggle", (tx_data ^ tx_strobe) != obs_x, 1'b1);
                end
                pd = nd;
                ps = ns;
            end
            if (cur[2]) chk("R2 R3 data bit", tx_data, nd);
            else        chk("R9 idle data", tx_data, 1'b0);
            chk("R7 strobe", tx_strobe, ns);
            chk("R10 drive enable", tx_drive_en, cur[2]);
            chk(cur[3] ? "R5 R6 link_clk half" : "R4 R6 link_clk full", link_clk, k < len / 2);
            obs_x = tx_data ^ tx_strobe;
        end
        @(negedge clk);
        prev_link = 1'b0;
        chk("R2 next period start", link_clk, 1'b1);
        prev_link = link_clk;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [3:0] cur;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 data", tx_data, 1'b0);
        chk("R1 strobe", tx_strobe, 1'b0);
        chk("R1 drive", tx_drive_en, 1'b0);
        chk("R1 link_clk", link_clk, 1'b1);
        rst = 1'b0;
        prev_link = 1'b1;
        wait_rise();

        // table walk
        cur = 4'b0000;
        for (int i = 0; i < NV + 2; i++) begin
            logic [3:0] nv;
            nv = (i < NV) ? VEC[i] : 4'b0000;
            run_period(cur, nv);
            cur = nv;
        end

        // directed: reset in the middle of enabled traffic (R1)
        run_period(cur, 4'b0111);
        cur = 4'b0111;
        drive(4'b0101);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-stream data", tx_data, 1'b0);
        chk("R1 mid-stream strobe", tx_strobe, 1'b0);
        chk("R1 mid-stream drive", tx_drive_en, 1'b0);
        chk("R1 mid-stream link_clk", link_clk, 1'b1);
        drive(4'b0000);
        @(negedge clk);
        rst = 1'b0;
        prev_link = 1'b1;
        pd = 1'b0;
        ps = 1'b0;
        wait_rise();

        // directed: first enabled word after reset is all zeros, then half-rate run of ones
        cur = 4'b0000;
        run_period(cur, 4'b0100);
        cur = 4'b0100;
        run_period(cur, 4'b1111);
        cur = 4'b1111;
        run_period(cur, 4'b1111);
        cur = 4'b1111;
        run_period(cur, 4'b0000);
        cur = 4'b0000;
        run_period(cur, 4'b0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule